// File: doc/BRIEF.md
# Measurement multiplexer sequence controller

This block chooses which measured quantity is placed on a shared differential output. A single external select strobe steps it through a fixed order of readings: for each active channel, first its bus voltage, then its shunt current, channel by channel in ascending order. After the last step the order starts again at the first channel. Before any reading is driven, the strobe must give one arming pulse, followed by a low gap of bounded length. If the strobe stays at one level for too long, the sequencer drops back to idle and waits to be armed again.

Two such controllers can share one output bus. In paired operation, the first device drives its readings while the second holds its output undriven. The two then swap, so exactly one device drives at any time. A channel whose current-output pin reads as floating ends the sequence: that channel and every higher channel are left out. While the enable state is anything other than full function, the sequencer is held idle and the output stays undriven. The outputs are a channel index, a voltage/current select bit and an output-drive enable. The analog path that uses them is outside the block.

Top module: `meas_mux_seq`

## Requirements
- R1: After reset and while idle, `drive_en`, `ch_idx` and `sel_current` are all 0.
- R2: In stand-alone mode with N active channels, each strobe rising edge advances one step in this order: channel 0 voltage, channel 0 current, channel 1 voltage, and so on up to channel N-1 current. The next step after that is channel 0 voltage again. `sel_current` is 0 for voltage and 1 for current.
- R3: Arming works as follows. After a strobe high pulse, the strobe stays low for G clock cycles with ARM_GAP_MIN <= G <= ARM_GAP_MAX. The next rising edge then starts the sequence at channel 0 voltage with the output driven.
- R4: A rising edge after a low gap outside that window does not start the sequence; the output stays undriven. That rising edge counts as a new arming pulse.
- R5: A strobe level that lasts more than STUCK_LIMIT clock cycles returns the sequencer to idle with the output undriven. A level that lasts exactly STUCK_LIMIT cycles does not.
- R6: `mode_code` 2'b00 selects the first device of a pair, 2'b10 the second device of a pair, and 2'b01 or 2'b11 stand-alone.
- R7: In paired mode with N active channels, the sequence is 4N steps long. The first device drives steps 0 to 2N-1 and the second device drives steps 2N to 4N-1. Both devices use the R2 order inside their own half, and each holds its output undriven during the other half.
- R8: N is the number of consecutive set bits of `ch_present` counted upward from bit 0; the first clear bit ends the count. When N is 0, the output is never driven.
- R9: While `en_state` is not 2'b00, the sequencer is held idle with the output undriven. After `en_state` returns to 2'b00, a new arming pulse and gap are needed before any output is driven.
- R10: Whenever `drive_en` is 0, `ch_idx` and `sel_current` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mux_strobe | input | 1 | Asynchronous select strobe; each rising edge is one step |
| mode_code | input | 2 | Mode level: 00 first of pair, 01/11 stand-alone, 10 second of pair |
| en_state | input | 2 | 00 full function; any other value holds the sequencer idle |
| ch_present | input | NUM_CH | Per-channel present flag (0 = current output floating) |
| ch_idx | output | IDX_W | Channel whose reading is selected |
| sel_current | output | 1 | 0 = bus voltage, 1 = shunt current |
| drive_en | output | 1 | 1 = drive the shared output, 0 = high impedance |

## Verification
The hardest states to reach are the exact edges of the timing windows. These are a low gap one cycle either side of the arming limits, and a strobe level held for exactly STUCK_LIMIT cycles against STUCK_LIMIT plus a few. Each needs a cycle-exact waveform that passes through the two-stage synchronizer. The bench overrides the limits with small values and drives the strobe on falling clock edges. Its tasks hold each level for an exact number of cycles, so the edge-to-edge durations seen inside the block match the counts the bench requested. Random runs then mix mode codes, present patterns with gaps, and strobe periods.

// File: rtl/meas_mux_pkg.sv
// Package: shared state, role types and encodings for the measurement
// multiplexer sequence controller.
package meas_mux_pkg;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for an arming pulse
        ST_ARM  = 2'd1,   // arming pulse high
        ST_GAP  = 2'd2,   // timing the low gap after arming
        ST_RUN  = 2'd3    // normal stepping
    } seq_state_t;

    // Role on the shared output bus
    typedef enum logic [1:0] {
        ROLE_A    = 2'd0,
        ROLE_SOLO = 2'd1,
        ROLE_B    = 2'd2
    } role_t;

    // Enable code that permits operation
    localparam logic [1:0] EN_FULL = 2'b00;

    // Map the three-level mode code onto a role
    function automatic role_t decode_role(input logic [1:0] code);
        case (code)
            2'b00:   return ROLE_A;
            2'b10:   return ROLE_B;
            default: return ROLE_SOLO;
        endcase
    endfunction

endpackage

// File: rtl/meas_mux_sync.sv
// Module: multi-stage synchronizer for asynchronous, level-type inputs.
// Assumes STAGES >= 2. All stages clear to zero on reset.
module meas_mux_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] pipe;

    // Shift the input through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[STAGES-2:0], din};
        end
    end

    assign dout = pipe[STAGES-1];

endmodule

// File: rtl/meas_mux_level_timer.sv
// Module: detects edges of the synchronized strobe and counts the clock
// cycles the current level has lasted. The count is 1 in the cycle after
// an edge and saturates at all ones. Assumes the input is already
// synchronized.
module meas_mux_level_timer #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             level,
    output logic             rise,
    output logic             fall,
    output logic [CNT_W-1:0] cnt
);

    logic level_d;

    // Remember the previous level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_d <= 1'b0;
        end else begin
            level_d <= level;
        end
    end

    assign rise = level & ~level_d;
    assign fall = ~level & level_d;

    // Count cycles at the current level, restarting on each edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (rise || fall) begin
            cnt <= CNT_W'(1);
        end else if (cnt != '1) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/meas_mux_chan_count.sv
// Module: counts the active channels, i.e. the run of set present flags
// starting at channel 0. The first clear flag ends the run.
// Assumes the flags are synchronized and quasi-static.
module meas_mux_chan_count #(
    parameter int NUM_CH = 4,
    parameter int N_W    = 3
) (
    input  logic [NUM_CH-1:0] present,
    output logic [N_W-1:0]    n_active
);

    logic [NUM_CH-1:0] prefix;

    // Prefix AND chain: a channel counts only if every lower one is present
    for (genvar g = 0; g < NUM_CH; g++) begin : g_prefix
        if (g == 0) begin : g_first
            assign prefix[g] = present[g];
        end else begin : g_rest
            assign prefix[g] = prefix[g-1] & present[g];
        end
    end

    // Population count of the prefix chain
    always_comb begin
        n_active = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            n_active = n_active + N_W'(prefix[i]);
        end
    end

endmodule

// File: rtl/meas_mux_step_fsm.sv
// Module: arming, timeout and step-position state machine.
// A rising edge in idle arms. The falling edge then starts gap timing, and
// a rising edge inside the gap window enters run at position 0. In run,
// each rising edge advances the position modulo the sequence length
// (2N stand-alone, 4N paired). A level held longer than the stuck limit
// returns to idle. Assumes ARM_GAP_MAX < STUCK_LIMIT < 2**CNT_W - 1.
module meas_mux_step_fsm
    import meas_mux_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int ARM_GAP_MIN = 738,
    parameter int ARM_GAP_MAX = 1212,
    parameter int STUCK_LIMIT = 1750000,
    parameter int CNT_W       = 21,
    parameter int N_W         = 3,
    parameter int POS_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             rise,
    input  logic             fall,
    input  logic [CNT_W-1:0] cnt,
    input  logic [N_W-1:0]   n_active,
    input  logic             paired,
    output seq_state_t       state_q,
    output logic [POS_W-1:0] pos_q
);

    localparam int PER_W = POS_W + 1;
    localparam logic [CNT_W-1:0] LIM_MIN   = CNT_W'(ARM_GAP_MIN);
    localparam logic [CNT_W-1:0] LIM_MAX   = CNT_W'(ARM_GAP_MAX);
    localparam logic [CNT_W-1:0] LIM_STUCK = CNT_W'(STUCK_LIMIT);

    seq_state_t       state_d;
    logic [POS_W-1:0] pos_d;
    logic [PER_W-1:0] period;
    logic [PER_W-1:0] pos_inc;
    logic [POS_W-1:0] pos_step;
    logic             any_edge;

    assign any_edge = rise | fall;

    // Sequence length and the wrapped next position
    always_comb begin
        period  = paired ? (PER_W'(n_active) << 2) : (PER_W'(n_active) << 1);
        pos_inc = PER_W'(pos_q) + 1'b1;
        if (pos_inc >= period) begin
            pos_step = '0;
        end else begin
            pos_step = POS_W'(pos_inc);
        end
    end

    // Next-state decision
    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        if (hold) begin
            state_d = ST_IDLE;
            pos_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (rise) state_d = ST_ARM;
                end
                ST_ARM: begin
                    if (fall) begin
                        state_d = ST_GAP;
                    end else if (cnt >= LIM_STUCK) begin
                        state_d = ST_IDLE;
                    end
                end
                ST_GAP: begin
                    if (rise) begin
                        if (cnt >= LIM_MIN && cnt <= LIM_MAX) begin
                            state_d = ST_RUN;
                            pos_d   = '0;
                        end else begin
                            state_d = ST_ARM;
                        end
                    end else if (cnt > LIM_MAX) begin
                        state_d = ST_IDLE;
                    end
                end
                ST_RUN: begin
                    if (rise) begin
                        pos_d = pos_step;
                    end else if (!any_edge && cnt >= LIM_STUCK) begin
                        state_d = ST_IDLE;
                        pos_d   = '0;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State and position registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pos_q   <= '0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
        end
    end

endmodule

// File: rtl/meas_mux_seq.sv
// Module: top of the measurement multiplexer sequence controller.
// Synchronizes the strobe and present flags, times strobe levels, runs the
// step state machine, and decodes the position into channel index,
// voltage/current select and drive enable for this device's role.
// Assumes mode_code and en_state are quasi-static; en_state acts at the
// next clock edge.
module meas_mux_seq
    import meas_mux_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int ARM_GAP_MIN = 738,
    parameter int ARM_GAP_MAX = 1212,
    parameter int STUCK_LIMIT = 1750000,
    parameter int SYNC_STAGES = 2,
    localparam int IDX_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mux_strobe,
    input  logic [1:0]        mode_code,
    input  logic [1:0]        en_state,
    input  logic [NUM_CH-1:0] ch_present,
    output logic [IDX_W-1:0]  ch_idx,
    output logic              sel_current,
    output logic              drive_en
);

    localparam int N_W   = $clog2(NUM_CH + 1);
    localparam int POS_W = $clog2(4 * NUM_CH);
    localparam int PER_W = POS_W + 1;
    localparam int CNT_W = $clog2(STUCK_LIMIT + 2);

    logic              strobe_s;
    logic [NUM_CH-1:0] present_s;
    logic              strobe_rise;
    logic              strobe_fall;
    logic              strobe_edge;
    logic [CNT_W-1:0]  level_cnt;
    logic [N_W-1:0]    n_active;
    seq_state_t        seq_state;
    logic [POS_W-1:0]  seq_pos;
    role_t             role;
    logic              hold;
    logic              paired;

    assign role        = decode_role(mode_code);
    assign paired      = (role != ROLE_SOLO);
    assign hold        = (en_state != EN_FULL);
    assign strobe_edge = strobe_rise | strobe_fall;

    meas_mux_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_sync_strobe (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (mux_strobe),
        .dout  (strobe_s)
    );

    meas_mux_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync_present (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ch_present),
        .dout  (present_s)
    );

    meas_mux_level_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .level (strobe_s),
        .rise  (strobe_rise),
        .fall  (strobe_fall),
        .cnt   (level_cnt)
    );

    meas_mux_chan_count #(.NUM_CH(NUM_CH), .N_W(N_W)) u_count (
        .present  (present_s),
        .n_active (n_active)
    );

    meas_mux_step_fsm #(
        .NUM_CH      (NUM_CH),
        .ARM_GAP_MIN (ARM_GAP_MIN),
        .ARM_GAP_MAX (ARM_GAP_MAX),
        .STUCK_LIMIT (STUCK_LIMIT),
        .CNT_W       (CNT_W),
        .N_W         (N_W),
        .POS_W       (POS_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .rise     (strobe_rise),
        .fall     (strobe_fall),
        .cnt      (level_cnt),
        .n_active (n_active),
        .paired   (paired),
        .state_q  (seq_state),
        .pos_q    (seq_pos)
    );

    logic [PER_W-1:0] pos_ext;
    logic [PER_W-1:0] half_len;
    logic [PER_W-1:0] local_pos;
    logic             in_b_half;
    logic             owns;
    logic             drive;

    // Decode position into this device's half and local step
    always_comb begin
        pos_ext   = PER_W'(seq_pos);
        half_len  = PER_W'(n_active) << 1;
        in_b_half = (pos_ext >= half_len);
        local_pos = in_b_half ? (pos_ext - half_len) : pos_ext;
        unique case (role)
            ROLE_A:  owns = !in_b_half;
            ROLE_B:  owns = in_b_half;
            default: owns = 1'b1;
        endcase
        drive = (seq_state == ST_RUN) && (n_active != '0) && owns
                && (local_pos < half_len);
    end

    assign drive_en    = drive;
    assign ch_idx      = drive ? local_pos[IDX_W:1] : '0;
    assign sel_current = drive & local_pos[0];

endmodule

// File: rtl/meas_mux_seq_chk.sv
// Checker: temporal properties of the sequence controller, bound to the top.
module meas_mux_seq_chk
    import meas_mux_pkg::*;
#(
    parameter int STUCK_LIMIT = 300,
    parameter int CNT_W       = 9,
    parameter int N_W         = 3,
    parameter int POS_W       = 4,
    parameter int IDX_W       = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       en_state,
    input logic             drive_en,
    input logic [IDX_W-1:0] ch_idx,
    input logic             sel_current,
    input seq_state_t       seq_state,
    input logic [POS_W-1:0] seq_pos,
    input logic             strobe_rise,
    input logic             strobe_edge,
    input logic [CNT_W-1:0] level_cnt,
    input logic [N_W-1:0]   n_active
);

    localparam logic [CNT_W-1:0] LIM = CNT_W'(STUCK_LIMIT);

    // R2: position only moves on a strobe rising edge (or clears on exit)
    a_r2_step_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_RUN && !strobe_rise) |=>
        (seq_pos == $past(seq_pos) || seq_state == ST_IDLE));

    // R3: run is entered only from the gap phase, at position 0
    a_r3_enter_from_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_state == ST_RUN) |-> ($past(seq_state) == ST_GAP && seq_pos == '0));

    // R5: a stuck level past the limit leaves run
    a_r5_stuck_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_RUN && !strobe_edge && level_cnt >= LIM) |=> seq_state == ST_IDLE);

    // R8: a driven index never reaches past the active channels
    a_r8_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> (N_W'(ch_idx) < n_active));

    // R9: a non-full enable state forces idle and no drive
    a_r9_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en_state != EN_FULL) |=> (seq_state == ST_IDLE && !drive_en));

    // R10: undriven output shows zero index and voltage select
    a_r10_quiet_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_en |-> (ch_idx == '0 && !sel_current));

endmodule

bind meas_mux_seq meas_mux_seq_chk #(
    .STUCK_LIMIT (STUCK_LIMIT),
    .CNT_W       (CNT_W),
    .N_W         (N_W),
    .POS_W       (POS_W),
    .IDX_W       (IDX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_state    (en_state),
    .drive_en    (drive_en),
    .ch_idx      (ch_idx),
    .sel_current (sel_current),
    .seq_state   (seq_state),
    .seq_pos     (seq_pos),
    .strobe_rise (strobe_rise),
    .strobe_edge (strobe_edge),
    .level_cnt   (level_cnt),
    .n_active    (n_active)
);

// File: tb/meas_mux_seq_test.sv
// Bench: directed corner cases plus seeded random sequences, checked
// against a bench-side model of the requirements.
module meas_mux_seq_test;

    localparam int NCH   = 4;
    localparam int GMIN  = 20;
    localparam int GMAX  = 40;
    localparam int STUCK = 300;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strobe = 1'b0;
    logic [1:0] mode = 2'b01;
    logic [1:0] en = 2'b00;
    logic [3:0] present = 4'hF;
    logic [1:0] ch_idx;
    logic       sel_current;
    logic       drive_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int k = 0;
    int n_cur = 4;

    always #10 clk = ~clk;

    meas_mux_seq #(
        .NUM_CH      (NCH),
        .ARM_GAP_MIN (GMIN),
        .ARM_GAP_MAX (GMAX),
        .STUCK_LIMIT (STUCK)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mux_strobe  (strobe),
        .mode_code   (mode),
        .en_state    (en),
        .ch_present  (present),
        .ch_idx      (ch_idx),
        .sel_current (sel_current),
        .drive_en    (drive_en)
    );

    // Count of consecutive present flags from channel 0 (R8)
    function automatic int lead_ones(input logic [3:0] p);
        int  n = 0;
        bit  run = 1'b1;
        for (int i = 0; i < 4; i++) begin
            if (run && p[i]) n++;
            else run = 1'b0;
        end
        return n;
    endfunction

    // Expected {drive, idx, current} for step s (R2, R6, R7, R8, R10)
    function automatic logic [3:0] expect_at(input int s, input int n, input logic [1:0] m);
        int period, pos, half;
        logic [31:0] loc;
        bit paired, b_half, own;
        if (n == 0) return 4'b0000;
        half   = 2 * n;
        paired = (m == 2'b00) || (m == 2'b10);
        period = paired ? 2 * half : half;
        pos    = s % period;
        b_half = (pos >= half);
        loc    = b_half ? pos - half : pos;
        own    = !paired || (m == 2'b00 && !b_half) || (m == 2'b10 && b_half);
        if (!own) return 4'b0000;
        return {1'b1, loc[2:1], loc[0]};
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_out(input string tag, input logic [3:0] e);
        logic [3:0] act;
        act = {drive_en, ch_idx, sel_current};
        checks++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s: got %b expected %b (step %0d)", tag, act, e, k);
        end
    endtask

    // Force idle through the enable input, then set up a new scenario
    task automatic restart(input logic [1:0] m, input logic [3:0] p);
        en = 2'b10;
        strobe = 1'b0;
        mode = m;
        present = p;
        tick(6);
        en = 2'b00;
        tick(3);
        k = 0;
        n_cur = lead_ones(p);
    endtask

    // Arming pulse, low gap of 'gap' cycles, then the first rising edge
    task automatic arm(input int gap);
        strobe = 1'b1;
        tick(6);
        strobe = 1'b0;
        tick(gap);
        strobe = 1'b1;
        tick(4);
    endtask

    // Extend the high level, go low for 'low' cycles, rise, settle
    task automatic step(input int low, input int extra_high);
        tick(extra_high);
        strobe = 1'b0;
        tick(low);
        strobe = 1'b1;
        tick(4);
        k++;
    endtask

    task automatic run_steps(input string tag, input int count);
        for (int i = 0; i < count; i++) begin
            step(5 + (i % 7), i % 3);
            check_out(tag, expect_at(k, n_cur, mode));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got no completion expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        // R1: reset state
        tick(5);
        check_out("R1 in reset", 4'b0000);
        rst_n = 1'b1;
        tick(3);
        check_out("R1 after reset", 4'b0000);

        // R3, R2: stand-alone full sequence and wrap
        restart(2'b01, 4'hF);
        check_out("R1 idle before arm", 4'b0000);
        arm(30);
        check_out("R3 first step", expect_at(0, 4, 2'b01));
        run_steps("R2", 10);

        // R3 / R4: gap window boundaries
        restart(2'b01, 4'hF);
        arm(GMIN - 1);
        check_out("R4 gap short", 4'b0000);
        strobe = 1'b0;
        tick(25);
        strobe = 1'b1;
        tick(4);
        check_out("R4 rejected rise re-arms", expect_at(0, 4, 2'b01));
        restart(2'b01, 4'hF);
        arm(GMIN);
        check_out("R3 gap at min", expect_at(0, 4, 2'b01));
        restart(2'b01, 4'hF);
        arm(GMAX);
        check_out("R3 gap at max", expect_at(0, 4, 2'b01));
        restart(2'b01, 4'hF);
        arm(GMAX + 1);
        check_out("R4 gap long", 4'b0000);

        // R5: stuck timeout boundaries
        restart(2'b01, 4'hF);
        arm(30);
        step(10, STUCK - 4);
        check_out("R5 high exactly limit", expect_at(k, 4, 2'b01));
        step(STUCK, 0);
        check_out("R5 low exactly limit", expect_at(k, 4, 2'b01));
        tick(STUCK + 10);
        check_out("R5 high stuck", 4'b0000);
        restart(2'b01, 4'hF);
        arm(30);
        strobe = 1'b0;
        tick(STUCK + 10);
        check_out("R5 low stuck", 4'b0000);
        strobe = 1'b1;
        tick(4);
        check_out("R5 rise after timeout only arms", 4'b0000);

        // R6, R7: paired roles and mode codes
        restart(2'b00, 4'hF);
        arm(25);
        check_out("R7 device A first", expect_at(0, 4, 2'b00));
        run_steps("R7 device A", 17);
        restart(2'b10, 4'hF);
        arm(25);
        check_out("R10 device B quiet", expect_at(0, 4, 2'b10));
        run_steps("R7 device B", 17);
        restart(2'b11, 4'h7);
        arm(25);
        run_steps("R6 code 11 stand-alone", 7);
        restart(2'b10, 4'h7);
        arm(25);
        run_steps("R6 code 10 device B", 13);

        // R8: truncation at first absent channel
        restart(2'b01, 4'b1011);
        arm(25);
        check_out("R8 truncated start", expect_at(0, 2, 2'b01));
        run_steps("R8 truncated", 6);
        restart(2'b01, 4'b1110);
        arm(25);
        check_out("R8 no channels", 4'b0000);
        run_steps("R8 no channels", 3);

        // R9: enable hold and re-arming
        restart(2'b01, 4'hF);
        arm(25);
        step(8, 0);
        step(8, 0);
        en = 2'b01;
        tick(2);
        check_out("R9 held when not full", 4'b0000);
        en = 2'b00;
        step(10, 0);
        check_out("R9 needs re-arm", 4'b0000);
        strobe = 1'b0;
        tick(30);
        strobe = 1'b1;
        tick(4);
        k = 0;
        check_out("R9 running after re-arm", expect_at(0, 4, 2'b01));

        // Random scenarios
        for (int r = 0; r < 24; r++) begin
            restart(2'($urandom_range(0, 3)), 4'($urandom_range(0, 15)));
            arm($urandom_range(GMIN, GMAX));
            check_out("R3 random start", expect_at(0, n_cur, mode));
            for (int s = 0; s < int'($urandom_range(4, 20)); s++) begin
                step($urandom_range(3, 30), $urandom_range(0, 30));
                check_out((mode == 2'b00 || mode == 2'b10) ? "R7 random" : "R2 random",
                          expect_at(k, n_cur, mode));
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule